// File: doc/BRIEF.md
# Short Packet Capture FIFO

This block sits behind a camera-serial-link packet decoder and keeps the generic short packets it reports. Each decoded packet arrives as a single-cycle strobe carrying a 6-bit data type, a 2-bit virtual channel and a 16-bit payload. Packets whose type lies in the generic short range are packed into one word and stored in a 31-entry first-in first-out buffer. Frame-sync and line-sync packets, and every other type, are discarded.

The host drains the buffer through a register read port. A read of the capture offset returns the oldest entry one cycle later and removes it. A read of any other offset returns zero and leaves the buffer alone. Two live status pins report full and not-empty. Two event pulses feed the interrupt logic. The not-empty event fires again after every accepted packet and after every pop that leaves entries behind, so a status bit the host has cleared sets again while data remains. The overflow event marks each packet that is lost because the buffer is full.

The packet input has no ready signal, because the decoder cannot be stalled. Back-pressure therefore takes the form of a drop: a generic packet that arrives while the buffer is full and is not matched by a pop in the same cycle is discarded. A synchronous soft reset empties the buffer without touching any configuration.

Top module: `short_pkt_fifo`

## Requirements
- R1: The buffer holds 31 entries; `sts_full` is 1 exactly when 31 entries are stored.
- R2: A returned entry has the payload in bits [23:8], the virtual channel in bits [7:6] and the data type in bits [5:0]; bits [31:24] are zero.
- R3: When `rd_req` is 1 with `rd_addr` = 0x30, the oldest entry appears on `rd_data` with `rd_valid` = 1 in the next cycle, and exactly one entry is removed. A read at any other address returns zero and removes nothing.
- R4: A capture-offset read of an empty buffer returns zero with `rd_valid` = 1, and the buffer stays empty.
- R5: A generic packet that arrives when the buffer is full, with no pop in the same cycle, is dropped. The stored entries are unchanged, and `evt_overflow` is 1 for exactly the next cycle.
- R6: `evt_not_empty` is a one-cycle pulse, in the cycle after any accepted packet and in the cycle after any pop that leaves at least one entry.
- R7: Only packets whose data type is 0x08 to 0x0F are stored. All other types, including frame and line sync (0x00 to 0x07), have no effect.
- R8: A push and a pop in the same cycle leave the count unchanged when the buffer is full, and both take effect. On an empty buffer, the pop returns zero and the packet is stored.
- R9: `soft_rst` = 1 empties the buffer by the next cycle. It clears both events and `rd_valid`, and it overrides any packet or read in the same cycle.
- R10: `sts_full` and `sts_not_empty` reflect the stored count, and they change in the cycle after the push or pop that alters it. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous buffer clear |
| pkt_valid | input | 1 | Decoded short packet strobe |
| pkt_dt | input | 6 | Packet data type |
| pkt_vc | input | 2 | Packet virtual channel |
| pkt_payload | input | 16 | Packet payload |
| rd_req | input | 1 | Host register read strobe |
| rd_addr | input | 8 | Host register read offset |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_req` |
| rd_data | output | 32 | Read data |
| sts_full | output | 1 | Live full status |
| sts_not_empty | output | 1 | Live not-empty status |
| evt_not_empty | output | 1 | Not-empty event pulse |
| evt_overflow | output | 1 | Overflow event pulse |

## Verification
Assertions check the following on every cycle:
- the count bound;
- that a drop, an ignored packet type or a read at a foreign offset leaves the count still;
- that a simultaneous push and pop holds the count;
- that soft reset empties the buffer;
- that an empty read yields zero;
- that overflow pulses only follow a drop.

First-in first-out ordering, the bit packing of each entry, and the fact that a drop does not corrupt the stored data show only in the bench scenarios. In those scenarios, a reference queue follows every step of a sweep over all 64 data types, a fill past full, and a drain past empty.

// File: rtl/short_pkt_pkg.sv
package short_pkt_pkg;
  localparam int DT_W = 6;
  localparam int VC_W = 2;
  localparam int PL_W = 16;

  typedef struct packed {
    logic [PL_W-1:0] payload;
    logic [VC_W-1:0] vc;
    logic [DT_W-1:0] dt;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);
endpackage

// File: rtl/short_pkt_filter.sv
module short_pkt_filter
  import short_pkt_pkg::*;
#(
  parameter int GEN_LO = 8,
  parameter int GEN_HI = 15
) (
  input  logic            pkt_valid,
  input  logic [DT_W-1:0] pkt_dt,
  output logic            keep
);
  // Generic short packets only; sync packets fall below GEN_LO.
  always_comb begin
    keep = pkt_valid && (int'(pkt_dt) >= GEN_LO) && (int'(pkt_dt) <= GEN_HI);
  end
endmodule

// File: rtl/short_pkt_ring.sv
module short_pkt_ring
  import short_pkt_pkg::*;
#(
  parameter int DEPTH = 31,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  entry_t           wdata,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             drop,
  output entry_t           head,
  output logic [CNT_W-1:0] count
);
  entry_t           mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             full, empty;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = (count == CNT_W'(DEPTH));
    empty   = (count == '0);
    pop_ok  = pop_req && !empty && !clr;
    push_ok = push && !clr && (!full || pop_ok);
    drop    = push && !clr && full && !pop_ok;
    head    = mem[rptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= step_ptr(wptr);
      if (pop_ok)  rptr <= step_ptr(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R1
  AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> count == $past(count)); // R5
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(count)); // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0); // R9
endmodule

// File: rtl/short_pkt_events.sv
module short_pkt_events #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  logic             drop,
  input  logic [CNT_W-1:0] count,
  output logic             evt_ne,
  output logic             evt_ovf
);
  logic ne_d;

  always_comb begin
    ne_d = push_ok || (pop_ok && count > CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_ne  <= 1'b0;
      evt_ovf <= 1'b0;
    end else if (clr) begin
      evt_ne  <= 1'b0;
      evt_ovf <= 1'b0;
    end else begin
      evt_ne  <= ne_d;
      evt_ovf <= drop;
    end
  end

  AST_OVF_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |-> $past(drop)); // R5
  AST_NE_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !clr) |=> evt_ne); // R6
endmodule

// File: rtl/short_pkt_fifo.sv
module short_pkt_fifo
  import short_pkt_pkg::*;
#(
  parameter int              DEPTH     = 31,
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] RD_OFFSET = 8'h30,
  parameter int              GEN_LO    = 8,
  parameter int              GEN_HI    = 15,
  localparam int             CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              pkt_valid,
  input  logic [DT_W-1:0]   pkt_dt,
  input  logic [VC_W-1:0]   pkt_vc,
  input  logic [PL_W-1:0]   pkt_payload,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sts_full,
  output logic              sts_not_empty,
  output logic              evt_not_empty,
  output logic              evt_overflow
);
  logic             keep, hit, push_ok, pop_ok, drop;
  entry_t           wdata, head;
  logic [CNT_W-1:0] count;

  always_comb begin
    wdata.payload = pkt_payload;
    wdata.vc      = pkt_vc;
    wdata.dt      = pkt_dt;
    hit           = rd_req && (rd_addr == RD_OFFSET);
    sts_full      = (count == CNT_W'(DEPTH));
    sts_not_empty = (count != '0);
  end

  short_pkt_filter #(.GEN_LO(GEN_LO), .GEN_HI(GEN_HI)) u_filter (
    .pkt_valid (pkt_valid),
    .pkt_dt    (pkt_dt),
    .keep      (keep)
  );

  short_pkt_ring #(.DEPTH(DEPTH)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_rst),
    .push    (keep),
    .wdata   (wdata),
    .pop_req (hit),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .drop    (drop),
    .head    (head),
    .count   (count)
  );

  short_pkt_events #(.CNT_W(CNT_W)) u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_rst),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .drop    (drop),
    .count   (count),
    .evt_ne  (evt_not_empty),
    .evt_ovf (evt_overflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req && !soft_rst;
      rd_data  <= pop_ok ? DATA_W'(head) : '0;
    end
  end

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !sts_not_empty && !soft_rst) |=> (rd_valid && rd_data == '0)); // R4
  AST_FOREIGN_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_addr != RD_OFFSET && !pkt_valid && !soft_rst)
      |=> ($stable(count) && rd_data == '0)); // R3
  AST_IGNORED_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && (int'(pkt_dt) < GEN_LO || int'(pkt_dt) > GEN_HI) && !rd_req && !soft_rst)
      |=> $stable(count)); // R7
endmodule

// File: tb/sim_short_pkt_fifo.sv
`timescale 1ns/1ps
module sim_short_pkt_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [5:0]  pkt_dt = '0;
  logic [1:0]  pkt_vc = '0;
  logic [15:0] pkt_payload = '0;
  logic        rd_req = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        sts_full, sts_not_empty, evt_not_empty, evt_overflow;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [23:0] q[$];

  always #2.5 clk = ~clk;

  short_pkt_fifo u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .pkt_valid(pkt_valid), .pkt_dt(pkt_dt), .pkt_vc(pkt_vc), .pkt_payload(pkt_payload),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .sts_full(sts_full), .sts_not_empty(sts_not_empty),
    .evt_not_empty(evt_not_empty), .evt_overflow(evt_overflow)
  );

  // One clock of stimulus; expected outputs come from a reference queue.
  task automatic step(input bit p, input logic [5:0] dt, input logic [1:0] vc,
                      input logic [15:0] pl, input bit r, input logic [7:0] a,
                      input bit s, input string tag);
    logic [36:0] exp_v, act_v;
    bit gen, pop, push, drp, e_ne;
    logic [31:0] e_data;
    int sz;
    @(negedge clk);
    soft_rst = s; pkt_valid = p; pkt_dt = dt; pkt_vc = vc; pkt_payload = pl;
    rd_req = r; rd_addr = a;
    sz   = q.size();
    gen  = p && dt >= 6'd8 && dt <= 6'd15;
    pop  = !s && r && a == 8'h30 && sz > 0;
    push = !s && gen && (sz < 31 || pop);
    drp  = !s && gen && sz == 31 && !pop;
    e_ne = push || (pop && sz > 1);
    e_data = pop ? {8'h00, q[0]} : 32'h0;
    if (pop) void'(q.pop_front());
    if (push) q.push_back({pl, vc, dt});
    if (s) q.delete();
    exp_v = {(r && !s), e_data, e_ne, drp, (q.size() > 0), (q.size() == 31)};
    @(posedge clk);
    #1;
    act_v = {rd_valid, rd_data, evt_not_empty, evt_overflow, sts_not_empty, sts_full};
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s: {vld,data,ne,ovf,sne,sfull} actual=%h expected=%h", tag, act_v, exp_v);
    end
    soft_rst = 1'b0; pkt_valid = 1'b0; rd_req = 1'b0;
  endtask

  task automatic idle(input string tag);
    step(1'b0, 6'd0, 2'd0, 16'd0, 1'b0, 8'h00, 1'b0, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b0, 6'd0, 2'd0, 16'd0, 1'b1, a, 1'b0, tag);
  endtask

  task automatic wr(input logic [5:0] dt, input logic [1:0] vc, input logic [15:0] pl, input string tag);
    step(1'b1, dt, vc, pl, 1'b0, 8'h00, 1'b0, tag);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if ({rd_valid, rd_data, evt_not_empty, evt_overflow, sts_not_empty, sts_full} !== 37'h0) begin
      failures++;
      $display("FAIL R10 reset state: actual=%h expected=0",
               {rd_valid, rd_data, evt_not_empty, evt_overflow, sts_not_empty, sts_full});
    end
    idle("R10 idle after reset");
    rd(8'h30, "R4 empty read");
    idle("R4 empty stays empty");
    // R7 R2 R6: sweep every data type, only 0x08..0x0F are kept
    for (int t = 0; t < 64; t++)
      wr(6'(t), 2'(t % 4), 16'(t * 517) ^ 16'h5a00, "R7 R6 type sweep");
    idle("R6 pulse ends");
    rd(8'h34, "R3 foreign offset no pop");
    rd(8'h00, "R3 foreign offset zero");
    for (int k = 0; k < 8; k++) rd(8'h30, "R2 R3 R6 ordered drain");
    rd(8'h30, "R4 read past empty");
    // R1 R5: fill to full, then overflow
    for (int i = 0; i < 31; i++)
      wr(6'(8 + i % 8), 2'(i % 4), 16'(i * 1021 + 7), "R1 R10 fill");
    wr(6'h0c, 2'd3, 16'hdead, "R5 overflow drop");
    idle("R5 overflow pulse one cycle");
    wr(6'h0a, 2'd1, 16'hbeef, "R5 second drop");
    step(1'b1, 6'h0b, 2'd2, 16'hcafe, 1'b1, 8'h30, 1'b0, "R8 push pop at full");
    step(1'b1, 6'h0d, 2'd0, 16'h1234, 1'b1, 8'h20, 1'b0, "R5 R3 foreign read at full drops");
    for (int k = 0; k < 32; k++) rd(8'h30, "R5 R2 drain after drops");
    // R8: push and pop together on empty
    step(1'b1, 6'h0f, 2'd1, 16'h7777, 1'b1, 8'h30, 1'b0, "R8 push pop at empty");
    rd(8'h30, "R8 entry kept after empty pop");
    // R9: soft reset
    for (int i = 0; i < 3; i++) wr(6'h08, 2'(i), 16'(i + 100), "R9 preload");
    step(1'b1, 6'h09, 2'd2, 16'h4321, 1'b1, 8'h30, 1'b1, "R9 soft reset overrides");
    rd(8'h30, "R9 empty after soft reset");
    wr(6'h0e, 2'd2, 16'h0f0f, "R9 usable after soft reset");
    rd(8'h30, "R9 R2 read after soft reset");
    idle("R6 final idle");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule